// File: doc/BRIEF.md
# Key-Sequenced Watchdog Controller

This block is the watchdog layer that rides on a 64-bit timer when that timer runs in its watchdog mode. Software drives it through a single 32-bit control word. The word carries a 16-bit key and an enable bit. Two specific keys must be written in order to arm the watchdog. Once armed, a free-running 64-bit counter climbs from zero. The watchdog then raises a reset pulse in two cases: software writes any key outside the service pair, or the counter catches up with the programmed period.

Software keeps an armed watchdog alive by writing the first key and then the second. That pair clears the counter. The two keys double as the arming sequence and as the service sequence. Before the watchdog is armed, a mistaken write only drops the sequence back to the start. After it is armed, the same mistake trips the reset. Once tripped, the block stays tripped until the next system reset. Control writes are accepted only while the timer's global mode field selects the watchdog (value 2) and both counter halves are released from reset.

The control write is a plain register strobe, so there is no stream interface and no back-pressure. A write is taken in the cycle its strobe is high.

Top module: `wdk_top`

## Requirements
- R1: After rst_n is released, wd_state reads 0 (idle), wd_count reads 0 and sys_rst_o is low.
- R2: In the control word the key is bits [31:16] and the enable flag is bit 14. All other bits are ignored. In idle, a write with enable set and key 0xA5C6 moves wd_state to 1 (pre-armed).
- R3: In pre-armed, a write with enable set and key 0xDA7E moves wd_state to 2 (armed) and clears wd_count. While the state is armed (2) or service-pending (3), wd_count rises by one every cycle.
- R4: In idle or pre-armed, any other accepted write returns wd_state to 0 and never raises sys_rst_o. This includes a repeated 0xA5C6 in pre-armed and any key written with the enable flag clear.
- R5: In idle and pre-armed, writes are ignored unless mode_sel equals 2 and both lo_run and hi_run are high.
- R6: In armed, key 0xA5C6 moves wd_state to 3 (service-pending). In service-pending, key 0xDA7E clears wd_count and returns wd_state to 2. In these two states the enable flag and the mode inputs have no effect.
- R7: In armed or service-pending, a write whose key is neither 0xA5C6 nor 0xDA7E moves wd_state to 4 (tripped) and starts the reset pulse.
- R8: In armed or service-pending, when wd_count is greater than or equal to period_i at a clock edge, the block trips. This expiry wins over a service write sampled on the same edge.
- R9: sys_rst_o goes high in the cycle after the tripping edge and stays high for exactly PULSE_LEN cycles (default 8). wd_state stays 4 and wd_count stops until rst_n is asserted.
- R10: In armed, key 0xDA7E without a preceding 0xA5C6 changes neither the state nor the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| mode_sel | input | 2 | Timer global mode field; 2 selects the watchdog |
| lo_run | input | 1 | Low counter half released from reset |
| hi_run | input | 1 | High counter half released from reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: key [31:16], enable bit 14 |
| period_i | input | 64 | Expiry period of the watchdog counter |
| wd_state | output | 3 | 0 idle, 1 pre-armed, 2 armed, 3 service-pending, 4 tripped |
| wd_count | output | 64 | Watchdog counter value |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
Every output is a register, so the effect of a write sampled at edge N shows at the next falling edge. That holds for a state change, a counter clear and the first reset-pulse cycle alike. Expiry trips on the edge where the counter first equals the period, which is edge period+1 after the arming edge. The pulse then holds for exactly PULSE_LEN falling-edge samples. The bench drives inputs and compares all three outputs on falling edges against a cycle model that advances on rising edges. The directed checks count edges by these same rules.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [2:0] {
    WD_IDLE = 3'd0,
    WD_PRE  = 3'd1,
    WD_LIVE = 3'd2,
    WD_SVC  = 3'd3,
    WD_TRIP = 3'd4
  } wd_state_e;

  typedef struct packed {
    logic wr;
    logic en;
    logic is_arm;
    logic is_go;
  } wd_cmd_t;
endpackage

// File: rtl/wdk_decode.sv
module wdk_decode
  import wdk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEY_W     = 16,
  parameter int KEY_LSB   = 16,
  parameter int EN_POS    = 14,
  parameter int MODE_W    = 2,
  parameter logic [MODE_W-1:0] MODE_WDOG = 2'd2,
  parameter logic [KEY_W-1:0]  ARM_KEY   = 16'hA5C6,
  parameter logic [KEY_W-1:0]  GO_KEY    = 16'hDA7E
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] mode,
  input  logic              lo_run,
  input  logic              hi_run,
  output wd_cmd_t           cmd,
  output logic              allowed
);
  localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

  logic [KEY_W-1:0] key;
  logic             unused_bits;

  assign key         = wr_data[KEY_MSB:KEY_LSB];
  assign unused_bits = ^{wr_data[KEY_LSB-1:EN_POS+1], wr_data[EN_POS-1:0]};

  always_comb begin
    cmd.wr     = wr_en;
    cmd.en     = wr_data[EN_POS];
    cmd.is_arm = (key == ARM_KEY);
    cmd.is_go  = (key == GO_KEY);
  end

  assign allowed = (mode == MODE_WDOG) && lo_run && hi_run;
endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
  import wdk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wd_cmd_t   cmd,
  input  logic      allowed,
  input  logic      expired,
  output wd_state_e state,
  output logic      fire,
  output logic      cnt_clr,
  output logic      cnt_run
);
  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    cnt_clr = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (cmd.wr && allowed)
          state_d = (cmd.en && cmd.is_arm) ? WD_PRE : WD_IDLE;
      end
      WD_PRE: begin
        if (cmd.wr && allowed) begin
          if (cmd.en && cmd.is_go) begin
            state_d = WD_LIVE;
            cnt_clr = 1'b1;
          end else begin
            state_d = WD_IDLE;
          end
        end
      end
      WD_LIVE, WD_SVC: begin
        if (expired) begin
          state_d = WD_TRIP;
          fire    = 1'b1;
        end else if (cmd.wr) begin
          if (cmd.is_arm) begin
            state_d = WD_SVC;
          end else if (cmd.is_go) begin
            cnt_clr = (state_q == WD_SVC);
            state_d = WD_LIVE;
          end else begin
            state_d = WD_TRIP;
            fire    = 1'b1;
          end
        end
      end
      default: state_d = WD_TRIP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WD_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign cnt_run = (state_q == WD_LIVE) || (state_q == WD_SVC);

  assert_trip_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_TRIP) |=> (state_q == WD_TRIP));
  assert_no_skip_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE) |=> (state_q == WD_IDLE || state_q == WD_PRE));
  assert_gate_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE && !allowed) |=> (state_q == WD_IDLE));
  assert_no_trip_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE || state_q == WD_PRE) |=> (state_q != WD_TRIP));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count   = cnt_q;
  assign expired = run && (cnt_q >= period);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);

  logic [PLS_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PLS_W'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - PLS_W'(1);
  end

  assign pulse = (left_q != '0);

  assert_pulse_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(fire));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 64,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              lo_run,
  input  logic              hi_run,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic [CNT_W-1:0]  period_i,
  output logic [2:0]        wd_state,
  output logic [CNT_W-1:0]  wd_count,
  output logic              sys_rst_o
);
  wd_cmd_t   cmd;
  wd_state_e st;
  logic      allowed, expired, fire, cnt_clr, cnt_run;

  wdk_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_en(ctl_wr), .wr_data(ctl_wdata), .mode(mode_sel),
    .lo_run(lo_run), .hi_run(hi_run), .cmd(cmd), .allowed(allowed)
  );

  wdk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .allowed(allowed), .expired(expired),
    .state(st), .fire(fire), .cnt_clr(cnt_clr), .cnt_run(cnt_run)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run),
    .period(period_i), .count(wd_count), .expired(expired)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(sys_rst_o)
  );

  assign wd_state = st;

  assert_pulse_only_tripped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (wd_state == 3'd4));
endmodule

// File: tb/wdk_top_bench.sv
module wdk_top_bench;
  localparam int PL = 8;
  localparam logic [15:0] KA = 16'hA5C6;
  localparam logic [15:0] KG = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd2;
  logic        lo_run = 1'b1, hi_run = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [63:0] period_i = 64'd1000;
  logic [2:0]  wd_state;
  logic [63:0] wd_count;
  logic        sys_rst_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  wdk_top #(.PULSE_LEN(PL)) u_wdk_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lo_run(lo_run), .hi_run(hi_run),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .period_i(period_i),
    .wd_state(wd_state), .wd_count(wd_count), .sys_rst_o(sys_rst_o)
  );

  // cycle model of the requirements
  logic [2:0]  m_st;
  logic [63:0] m_cnt;
  int          m_pls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 3'd0; m_cnt <= '0; m_pls <= 0;
    end else begin : step
      logic [15:0] k; logic en, ok, arm, go, f;
      logic [2:0] ns; logic [63:0] nc;
      k = ctl_wdata[31:16]; en = ctl_wdata[14];
      ok = (mode_sel == 2'd2) && lo_run && hi_run;
      arm = (k == KA); go = (k == KG);
      ns = m_st; nc = m_cnt; f = 1'b0;
      case (m_st)
        3'd0: if (ctl_wr && ok) ns = (en && arm) ? 3'd1 : 3'd0;
        3'd1: if (ctl_wr && ok) begin
                if (en && go) begin ns = 3'd2; nc = '0; end else ns = 3'd0;
              end
        3'd2, 3'd3: begin
          nc = m_cnt + 64'd1;
          if (m_cnt >= period_i) begin ns = 3'd4; f = 1'b1; end
          else if (ctl_wr) begin
            if (arm) ns = 3'd3;
            else if (go) begin if (m_st == 3'd3) nc = '0; ns = 3'd2; end
            else begin ns = 3'd4; f = 1'b1; end
          end
        end
        default: ;
      endcase
      m_st <= ns; m_cnt <= nc;
      m_pls <= f ? PL : ((m_pls != 0) ? m_pls - 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (wd_state !== m_st || wd_count !== m_cnt || sys_rst_o !== (m_pls != 0)) begin
        n_bad++;
        $display("FAIL model R3 R6 R7 R8 R9: state %0d cnt %0d rst %0b, expected %0d %0d %0b",
                 wd_state, wd_count, sys_rst_o, m_st, m_cnt, (m_pls != 0));
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] key, input logic en);
    ctl_wdata = {key, 1'b0, en, 14'h1A5};
    ctl_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm_it();
    wr(KA, 1'b1); wr(KG, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", wd_state, 0); chk("R1 count", wd_count, 0); chk("R1 rst", sys_rst_o, 0);

    mode_sel = 2'd1; wr(KA, 1'b1); chk("R5 mode gate", wd_state, 0);
    mode_sel = 2'd2; lo_run = 1'b0; wr(KA, 1'b1); chk("R5 half gate", wd_state, 0);
    lo_run = 1'b1;
    wr(KA, 1'b1); chk("R2 pre-armed", wd_state, 1);
    wr(KA, 1'b1); chk("R4 repeat key", wd_state, 0); chk("R4 no pulse", sys_rst_o, 0);
    wr(KA, 1'b0); chk("R4 enable clear", wd_state, 0);
    wr(KA, 1'b1); wr(16'h1234, 1'b1); chk("R4 bad key pre", wd_state, 0);
    chk("R4 no pulse bad", sys_rst_o, 0);

    arm_it(); chk("R3 armed", wd_state, 2); chk("R3 cleared", wd_count, 0);
    repeat (5) @(negedge clk); chk("R3 counting", wd_count, 5);
    wr(KG, 1'b1); chk("R10 lone go state", wd_state, 2); chk("R10 lone go count", wd_count, 6);
    wr(KA, 1'b0); chk("R6 service pending", wd_state, 3); chk("R6 count", wd_count, 7);
    wr(KG, 1'b0); chk("R6 serviced", wd_state, 2); chk("R6 cleared", wd_count, 0);
    ctl_wdata = 32'h0000_4000; ctl_wr = 1'b1; @(posedge clk); @(negedge clk); ctl_wr = 1'b0;
    chk("R7 tripped", wd_state, 4); chk("R7 pulse", sys_rst_o, 1);
    repeat (PL - 1) @(negedge clk); chk("R9 pulse held", sys_rst_o, 1);
    @(negedge clk); chk("R9 pulse ended", sys_rst_o, 0);
    wr(KA, 1'b1); chk("R9 stays tripped", wd_state, 4);

    do_reset(); period_i = 64'd10;
    arm_it(); repeat (10) @(negedge clk);
    chk("R8 before expiry", wd_state, 2); chk("R8 count", wd_count, 10);
    @(negedge clk); chk("R8 expired", wd_state, 4); chk("R8 pulse", sys_rst_o, 1);

    do_reset();
    arm_it(); repeat (9) @(negedge clk);
    wr(KA, 1'b1); chk("R8 svc pending", wd_state, 3);
    wr(KG, 1'b1); chk("R8 expiry wins", wd_state, 4);

    for (int ep = 0; ep < 12; ep++) begin
      do_reset();
      period_i = 64'(20 + ($urandom % 120));
      for (int c = 0; c < 300; c++) begin
        int r;
        r = int'($urandom % 100);
        mode_sel = (($urandom % 10) == 0) ? 2'd0 : 2'd2;
        lo_run = (($urandom % 20) != 0);
        hi_run = (($urandom % 20) != 0);
        ctl_wr = (r < 30);
        r = int'($urandom % 100);
        ctl_wdata = {(r < 46) ? KA : ((r < 92) ? KG : 16'($urandom)),
                     1'($urandom), 1'(($urandom % 8) != 0), 14'($urandom)};
        @(negedge clk);
      end
      ctl_wr = 1'b0; mode_sel = 2'd2; lo_run = 1'b1; hi_run = 1'b1;
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule